// File: doc/BRIEF.md
# Program ROM/RAM bank mapper

This block sits between a CPU address bus and two external memories: a program ROM and a battery or work RAM. For every CPU access in the range 0x6000 to 0xFFFF it decides which memory answers. It also forms the banked address for that memory, and it gates RAM writes. The translation is set by a small bank of configuration registers. The CPU loads them through a simple select/data write port.

The upper 32 KB can be cut into one, two, three or four windows, depending on a 2-bit page-size mode. Bit 7 of a switchable bank value picks ROM (bits 6:0 are the 8 KB ROM page) or RAM (bits 2:0 are the 8 KB RAM page). The top 8 KB always comes from ROM. The 8 KB at 0x6000 always comes from RAM, using its own bank register. RAM writes go through only while two lock registers hold a fixed two-part code.

The parameter `RAM_KB` gives the RAM size fitted (8, 16, 32 or 64). A RAM page number is folded to fit that size. A page that does not exist raises an open-bus flag, so the data bus can float.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset the four bank registers, the RAM bank register and both lock registers read as 0xFF and the mode is 3. So 0x8000 maps ROM page 0x7F, 0x6000 maps RAM page 7, and RAM writes are blocked.
- R2: In mode 0 the range 0x8000–0xFFFF is one ROM window. Its 8 KB ROM page is bank 1 bits 6:2 followed by address bits 14:13. Bank 1 bit 7 has no effect.
- R3: In mode 1, 0x8000–0xBFFF is a 16 KB window from bank 1. 0xC000–0xFFFF is a 16 KB ROM window whose page is bank 3 bits 6:1 followed by address bit 13.
- R4: In mode 2, 0x8000–0xBFFF is a 16 KB window from bank 1. 0xC000–0xDFFF is an 8 KB window from bank 2, and 0xE000–0xFFFF is an 8 KB ROM window from bank 3 bits 6:0.
- R5: In mode 3, 0x8000, 0xA000 and 0xC000 are 8 KB windows from banks 0, 1 and 2. In every mode, 0xE000–0xFFFF selects ROM whatever bank 3 bit 7 holds.
- R6: In a switchable window, bank bit 7 = 1 selects ROM (8 KB window: page = bits 6:0). Bit 7 = 0 selects RAM (8 KB window: page = bits 2:0). For a 16 KB RAM window the page is bits 2:1 followed by address bit 13.
- R7: 0x6000–0x7FFF always selects RAM, with its page taken from RAM bank register bits 2:0.
- R8: An access to a ROM window never raises the RAM write enable, even with writes unlocked.
- R9: The RAM write enable rises only on a write to a present RAM page while lock A bits 1:0 = 2 and lock B bits 1:0 = 1. Upper lock bits are ignored.
- R10: RAM page folding depends on RAM_KB. For 8, pages 0–3 map to page 0 and pages 4–7 are absent. For 16, the page becomes its bit 2. For 32, pages 0–3 map directly and pages 4–7 are absent. For 64, all pages map directly. An absent page raises openBus, with neither select and no write enable.
- R11: Below 0x6000 neither select nor openBus is raised.
- R12: The register select encoding is 0–3 for banks 0–3, 4 for the RAM bank, 5 for the mode (data bits 1:0), 6 for lock A and 7 for lock B. A write takes effect at the clock edge where regWe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWe | input | 1 | Configuration register write strobe |
| regSel | input | 3 | Configuration register select |
| regData | input | 8 | Configuration write data |
| cpuAddr | input | 16 | CPU address |
| cpuWe | input | 1 | CPU access is a write |
| romSel | output | 1 | Access maps to program ROM |
| ramSel | output | 1 | Access maps to a present RAM page |
| openBus | output | 1 | Access maps to an absent RAM page |
| romAddr | output | 20 | ROM byte address (page, offset) |
| ramAddr | output | 16 | RAM byte address (folded page, offset) |
| ramWe | output | 1 | RAM write enable |

## Verification
The bench builds the mapper four times side by side, with RAM_KB set to 64, 32, 16 and 8, and drives all four from the same inputs. The 64 KB copy covers every mode and window through the vector table. The smaller copies bring each folding rule within reach: absent pages at 8 and 32 KB, and the bit-2 fold at 16 KB. Each is checked with the same page numbers, so the four results can be compared directly.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
  localparam int BANK_W    = 8;
  localparam int ROM_PG_W  = 7;
  localparam int RAM_PG_W  = 3;
  localparam int OFF_W     = 13;
  localparam int N_BANKS   = 4;

  typedef enum logic [2:0] {
    SEL_BANK0   = 3'd0,
    SEL_BANK1   = 3'd1,
    SEL_BANK2   = 3'd2,
    SEL_BANK3   = 3'd3,
    SEL_RAMBANK = 3'd4,
    SEL_MODE    = 3'd5,
    SEL_LOCKA   = 3'd6,
    SEL_LOCKB   = 3'd7
  } regSel_e;

  typedef struct packed {
    logic       ramWriteOk;
    logic [1:0] pageMode;
  } ctrlStrobe_t;
endpackage

// File: rtl/prg_map_ctrl.sv
module prg_map_ctrl
  import prg_map_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           regWe,
  input  logic [2:0]                     regSel,
  input  logic [BANK_W-1:0]              regData,
  output logic [N_BANKS-1:0][BANK_W-1:0] bankRegs,
  output logic [BANK_W-1:0]              ramBankReg,
  output ctrlStrobe_t                    strobe
);
  logic [BANK_W-1:0] lockA, lockB;
  logic [1:0]        modeReg;

  for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)                                    bankRegs[g] <= '1;
      else if (regWe && regSel == 3'(g))          bankRegs[g] <= regData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ramBankReg <= '1;
      modeReg    <= 2'd3;
      lockA      <= '1;
      lockB      <= '1;
    end else if (regWe) begin
      case (regSel_e'(regSel))
        SEL_RAMBANK: ramBankReg <= regData;
        SEL_MODE:    modeReg    <= regData[1:0];
        SEL_LOCKA:   lockA      <= regData;
        SEL_LOCKB:   lockB      <= regData;
        default:     ;
      endcase
    end
  end

  assign strobe.pageMode   = modeReg;
  assign strobe.ramWriteOk = (lockA[1:0] == 2'd2) && (lockB[1:0] == 2'd1);

  a_r12_mode_write: assert property (@(posedge clk) disable iff (rst)
    (regWe && regSel == SEL_MODE) |=> strobe.pageMode == $past(regData[1:0]));
  a_r9_unlock_stable: assert property (@(posedge clk) disable iff (rst)
    !regWe |=> $stable(strobe.ramWriteOk));
  a_r1_reset_mode: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (strobe.pageMode == 2'd3 && !strobe.ramWriteOk));
endmodule

// File: rtl/prg_map_dp.sv
module prg_map_dp
  import prg_map_pkg::*;
#(
  parameter int RAM_KB = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [15:0]                    cpuAddr,
  input  logic                           cpuWe,
  input  logic [N_BANKS-1:0][BANK_W-1:0] bankRegs,
  input  logic [BANK_W-1:0]              ramBankReg,
  input  ctrlStrobe_t                    strobe,
  output logic                           romSel,
  output logic                           ramSel,
  output logic                           openBus,
  output logic [ROM_PG_W+OFF_W-1:0]      romAddr,
  output logic [RAM_PG_W+OFF_W-1:0]      ramAddr,
  output logic                           ramWe
);
  logic [2:0]          slot;
  logic                inRange;
  logic                useRom;
  logic [ROM_PG_W-1:0] romPage;
  logic [RAM_PG_W-1:0] rawPage, foldPage;
  logic                pagePresent;
  logic [BANK_W-1:0]   pick;

  assign slot    = cpuAddr[15:13];
  assign inRange = slot >= 3'd3;

  always_comb begin
    useRom  = 1'b0;
    romPage = '0;
    rawPage = '0;
    pick    = '0;
    if (slot == 3'd3) begin
      rawPage = ramBankReg[2:0];
    end else begin
      case (strobe.pageMode)
        2'd0: begin
          useRom  = 1'b1;
          romPage = {bankRegs[1][6:2], cpuAddr[14:13]};
        end
        2'd1, 2'd2: begin
          if (!cpuAddr[14]) begin
            pick    = bankRegs[1];
            useRom  = pick[7];
            romPage = {pick[6:1], cpuAddr[13]};
            rawPage = {pick[2:1], cpuAddr[13]};
          end else if (strobe.pageMode == 2'd1) begin
            useRom  = 1'b1;
            romPage = {bankRegs[3][6:1], cpuAddr[13]};
          end else if (slot == 3'd6) begin
            pick    = bankRegs[2];
            useRom  = pick[7];
            romPage = pick[6:0];
            rawPage = pick[2:0];
          end else begin
            useRom  = 1'b1;
            romPage = bankRegs[3][6:0];
          end
        end
        default: begin
          if (slot == 3'd7) begin
            useRom  = 1'b1;
            romPage = bankRegs[3][6:0];
          end else begin
            pick    = bankRegs[slot[1:0]];
            useRom  = pick[7];
            romPage = pick[6:0];
            rawPage = pick[2:0];
          end
        end
      endcase
    end
  end

  if (RAM_KB == 8) begin : g_fold8
    assign foldPage    = '0;
    assign pagePresent = !rawPage[2];
  end else if (RAM_KB == 16) begin : g_fold16
    assign foldPage    = {2'b00, rawPage[2]};
    assign pagePresent = 1'b1;
  end else if (RAM_KB == 32) begin : g_fold32
    assign foldPage    = rawPage;
    assign pagePresent = !rawPage[2];
  end else begin : g_fold64
    assign foldPage    = rawPage;
    assign pagePresent = 1'b1;
  end

  assign romSel  = inRange && useRom;
  assign ramSel  = inRange && !useRom && pagePresent;
  assign openBus = inRange && !useRom && !pagePresent;
  assign romAddr = {romPage, cpuAddr[OFF_W-1:0]};
  assign ramAddr = {foldPage, cpuAddr[OFF_W-1:0]};
  assign ramWe   = ramSel && cpuWe && strobe.ramWriteOk;

  a_r10_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({romSel, ramSel, openBus}));
  a_r5_top_is_rom: assert property (@(posedge clk) disable iff (rst)
    (cpuAddr[15:13] == 3'd7) |-> romSel);
  a_r7_low_not_rom: assert property (@(posedge clk) disable iff (rst)
    (cpuAddr[15:13] == 3'd3) |-> !romSel);
  a_r8_rom_no_write: assert property (@(posedge clk) disable iff (rst)
    romSel |-> !ramWe);
  a_r11_below_idle: assert property (@(posedge clk) disable iff (rst)
    (cpuAddr < 16'h6000) |-> !(romSel || ramSel || openBus));
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int RAM_KB = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        regWe,
  input  logic [2:0]  regSel,
  input  logic [7:0]  regData,
  input  logic [15:0] cpuAddr,
  input  logic        cpuWe,
  output logic        romSel,
  output logic        ramSel,
  output logic        openBus,
  output logic [19:0] romAddr,
  output logic [15:0] ramAddr,
  output logic        ramWe
);
  logic [N_BANKS-1:0][BANK_W-1:0] bankRegs;
  logic [BANK_W-1:0]              ramBankReg;
  ctrlStrobe_t                    strobe;

  prg_map_ctrl u_ctrl (
    .clk(clk), .rst(rst), .regWe(regWe), .regSel(regSel), .regData(regData),
    .bankRegs(bankRegs), .ramBankReg(ramBankReg), .strobe(strobe)
  );

  prg_map_dp #(.RAM_KB(RAM_KB)) u_dp (
    .clk(clk), .rst(rst), .cpuAddr(cpuAddr), .cpuWe(cpuWe),
    .bankRegs(bankRegs), .ramBankReg(ramBankReg), .strobe(strobe),
    .romSel(romSel), .ramSel(ramSel), .openBus(openBus),
    .romAddr(romAddr), .ramAddr(ramAddr), .ramWe(ramWe)
  );
endmodule

// File: tb/prg_bank_mapper_bench.sv
`timescale 1ns/1ps
module prg_bank_mapper_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWe = 1'b0;
  logic [2:0]  regSel = '0;
  logic [7:0]  regData = '0;
  logic [15:0] cpuAddr = '0;
  logic        cpuWe = 1'b0;

  logic [3:0]  romSelV, ramSelV, openV, weV;
  logic [19:0] romAddrV [4];
  logic [15:0] ramAddrV [4];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prg_bank_mapper #(.RAM_KB(64)) u_prg_bank_mapper (
    .clk(clk), .rst(rst), .regWe(regWe), .regSel(regSel), .regData(regData),
    .cpuAddr(cpuAddr), .cpuWe(cpuWe), .romSel(romSelV[0]), .ramSel(ramSelV[0]),
    .openBus(openV[0]), .romAddr(romAddrV[0]), .ramAddr(ramAddrV[0]), .ramWe(weV[0]));
  prg_bank_mapper #(.RAM_KB(32)) u_prg_bank_mapper_k32 (
    .clk(clk), .rst(rst), .regWe(regWe), .regSel(regSel), .regData(regData),
    .cpuAddr(cpuAddr), .cpuWe(cpuWe), .romSel(romSelV[1]), .ramSel(ramSelV[1]),
    .openBus(openV[1]), .romAddr(romAddrV[1]), .ramAddr(ramAddrV[1]), .ramWe(weV[1]));
  prg_bank_mapper #(.RAM_KB(16)) u_prg_bank_mapper_k16 (
    .clk(clk), .rst(rst), .regWe(regWe), .regSel(regSel), .regData(regData),
    .cpuAddr(cpuAddr), .cpuWe(cpuWe), .romSel(romSelV[2]), .ramSel(ramSelV[2]),
    .openBus(openV[2]), .romAddr(romAddrV[2]), .ramAddr(ramAddrV[2]), .ramWe(weV[2]));
  prg_bank_mapper #(.RAM_KB(8)) u_prg_bank_mapper_k8 (
    .clk(clk), .rst(rst), .regWe(regWe), .regSel(regSel), .regData(regData),
    .cpuAddr(cpuAddr), .cpuWe(cpuWe), .romSel(romSelV[3]), .ramSel(ramSelV[3]),
    .openBus(openV[3]), .romAddr(romAddrV[3]), .ramAddr(ramAddrV[3]), .ramWe(weV[3]));

  // kind: 0 none, 1 ROM, 2 RAM, 3 open bus
  typedef struct packed {
    logic [1:0]  mode;
    logic [7:0]  b0, b1, b2, b3;
    logic [15:0] addr;
    logic [1:0]  kind;
    logic [19:0] eaddr;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 8'h81, 8'h02, 8'h83, 8'h84, 16'h8123, 2'd1, 20'h02123, 8'd5},  // R5
    '{2'd3, 8'h81, 8'h02, 8'h83, 8'h84, 16'hA456, 2'd2, 20'h04456, 8'd6},  // R6
    '{2'd3, 8'h81, 8'h02, 8'h83, 8'h84, 16'hC010, 2'd1, 20'h06010, 8'd5},
    '{2'd3, 8'h81, 8'h02, 8'h83, 8'h84, 16'hFFFF, 2'd1, 20'h09FFF, 8'd5},
    '{2'd3, 8'h81, 8'h02, 8'h83, 8'h84, 16'h6ABC, 2'd2, 20'h0AABC, 8'd7},  // R7
    '{2'd0, 8'h00, 8'h8D, 8'h00, 8'h00, 16'hB001, 2'd1, 20'h1B001, 8'd2},  // R2
    '{2'd0, 8'h00, 8'h0D, 8'h00, 8'h00, 16'hE002, 2'd1, 20'h1E002, 8'd2},
    '{2'd1, 8'h00, 8'h87, 8'h00, 8'h15, 16'hA100, 2'd1, 20'h0E100, 8'd3},  // R3
    '{2'd1, 8'h00, 8'h87, 8'h00, 8'h15, 16'hD000, 2'd1, 20'h29000, 8'd3},
    '{2'd1, 8'h00, 8'h06, 8'h00, 8'h15, 16'h8010, 2'd2, 20'h0C010, 8'd6},
    '{2'd1, 8'h00, 8'h06, 8'h00, 8'h15, 16'hA010, 2'd2, 20'h0E010, 8'd6},
    '{2'd2, 8'h00, 8'h03, 8'h05, 8'h00, 16'hA000, 2'd2, 20'h06000, 8'd4},  // R4
    '{2'd2, 8'h00, 8'h03, 8'h05, 8'h00, 16'hC001, 2'd2, 20'h0A001, 8'd4},
    '{2'd2, 8'h00, 8'h03, 8'h90, 8'h00, 16'hDFFF, 2'd1, 20'h21FFF, 8'd4},
    '{2'd2, 8'h00, 8'h03, 8'h90, 8'h7F, 16'hE000, 2'd1, 20'hFE000, 8'd5},
    '{2'd3, 8'h00, 8'h00, 8'h00, 8'h02, 16'hF000, 2'd1, 20'h05000, 8'd5},
    '{2'd3, 8'h00, 8'h00, 8'h00, 8'h02, 16'h5FFF, 2'd0, 20'h00000, 8'd11} // R11
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] sel, input logic [7:0] data);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regData = data;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic access(input logic [15:0] a, input logic we);
    @(negedge clk);
    cpuAddr = a; cpuWe = we;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    access(16'h8000, 1'b1);
    chk("R1 romSel @8000", 32'(romSelV[0]), 32'd1);
    chk("R1 romAddr @8000", 32'(romAddrV[0]), 32'hFE000);
    access(16'h6000, 1'b1);
    chk("R1 ramSel @6000", 32'(ramSelV[0]), 32'd1);
    chk("R1 ramAddr @6000", 32'(ramAddrV[0]), 32'hE000);
    chk("R1 writes locked", 32'(weV[0]), 32'd0);

    // R9 unlock code
    wrReg(3'd6, 8'h02);
    wrReg(3'd7, 8'h01);
    access(16'h6010, 1'b1);
    chk("R9 unlocked we", 32'(weV[0]), 32'd1);
    access(16'h6010, 1'b0);
    chk("R9 read no we", 32'(weV[0]), 32'd0);
    wrReg(3'd7, 8'h03);
    access(16'h6010, 1'b1);
    chk("R9 wrong lockB", 32'(weV[0]), 32'd0);
    wrReg(3'd6, 8'h06);
    wrReg(3'd7, 8'h05);
    access(16'h6010, 1'b1);
    chk("R9 upper bits ignored", 32'(weV[0]), 32'd1);

    // R12 register select encoding, table walk over modes and windows
    wrReg(3'd4, 8'h05);
    for (int i = 0; i < NV; i++) begin
      string tag;
      wrReg(3'd5, {6'd0, VECS[i].mode});
      wrReg(3'd0, VECS[i].b0);
      wrReg(3'd1, VECS[i].b1);
      wrReg(3'd2, VECS[i].b2);
      wrReg(3'd3, VECS[i].b3);
      access(VECS[i].addr, 1'b1);
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      chk({tag, " romSel"},  32'(romSelV[0]), 32'(VECS[i].kind == 2'd1));
      chk({tag, " ramSel"},  32'(ramSelV[0]), 32'(VECS[i].kind == 2'd2));
      chk({tag, " openBus"}, 32'(openV[0]),   32'(VECS[i].kind == 2'd3));
      chk({tag, " ramWe R8"}, 32'(weV[0]),    32'(VECS[i].kind == 2'd2));
      if (VECS[i].kind == 2'd1) chk({tag, " romAddr"}, 32'(romAddrV[0]), 32'(VECS[i].eaddr));
      if (VECS[i].kind == 2'd2) chk({tag, " ramAddr"}, 32'(ramAddrV[0]), 32'(VECS[i].eaddr));
    end

    // R10 folding: page 6 then page 3 in window 0x8000, sizes 64/32/16/8
    wrReg(3'd5, 8'h03);
    wrReg(3'd0, 8'h06);
    access(16'h8004, 1'b1);
    chk("R10 k64 page6", 32'(ramAddrV[0]), 32'hC004);
    chk("R10 k32 page6 open", 32'({openV[1], ramSelV[1], weV[1]}), 32'b100);
    chk("R10 k16 page6 sel", 32'(ramSelV[2]), 32'd1);
    chk("R10 k16 page6 addr", 32'(ramAddrV[2]), 32'h2004);
    chk("R10 k8 page6 open", 32'({openV[3], ramSelV[3], weV[3]}), 32'b100);
    wrReg(3'd0, 8'h03);
    access(16'h8004, 1'b1);
    chk("R10 k64 page3", 32'(ramAddrV[0]), 32'h6004);
    chk("R10 k32 page3", 32'({ramSelV[1], ramAddrV[1]}), 32'h16004);
    chk("R10 k16 page3", 32'({ramSelV[2], ramAddrV[2]}), 32'h10004);
    chk("R10 k8 page3", 32'({ramSelV[3], ramAddrV[3]}), 32'h10004);

    // R6: bank bit 7 switches the same window from RAM to ROM
    wrReg(3'd0, 8'h83);
    access(16'h8004, 1'b1);
    chk("R6 rom via bit7", 32'({romSelV[0], romAddrV[0]}), 32'h106004);
    chk("R8 rom write blocked", 32'(weV[0]), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule